// File: doc/BRIEF.md
# Programmable Home Tile Lookup Table

Each tile of a tiled multicore keeps a small lookup table that tells it which tile acts as the first-level directory home for a given cache block. Privileged software fills the table whenever it places a virtual machine onto a set of tiles. A virtual machine that owns only a few tiles can list the same tile identifier in many entries, so that its homes are spread over its own tiles only. The mapping therefore follows the software's placement. It is not a fixed hash of the address.

A lookup presents a physical address. The block offset is dropped, and the next block-number bits above it select one table entry. The home tile identifier comes back on the next cycle. The configuration port writes one whole entry per clock edge, so a lookup never sees a partly written entry. A lookup that meets a write to the same entry on the same edge gets the value the entry held before the write.

Top module: `home_tile_map`

## Requirements
- R1: While reset is asserted and right after it is released, every entry holds the local tile identifier LOCAL_TILE (default 13), and rsp_valid is low.
- R2: The table index is address bits [OFS_W+IDX_W-1:OFS_W], which is [11:6] with the defaults. Address bits below and above that field do not change the result.
- R3: A lookup accepted on a rising edge with lkp_valid high drives rsp_valid high for exactly the following cycle. With lkp_valid low, rsp_valid is low in the following cycle.
- R4: After cfg_we writes cfg_tile into entry cfg_idx, every later lookup of that entry returns cfg_tile until the entry is written again.
- R5: A lookup and a write that hit the same entry on the same edge return the entry's old value. The new value is returned from the next lookup onward.
- R6: A write changes only the addressed entry. All other entries keep their values.
- R7: The same tile identifier may be stored in any number of entries, and each of those entries returns it.
- R8: While no lookup is accepted, rsp_tile keeps its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write enable for one table entry |
| cfg_idx | input | IDX_W | Entry to write |
| cfg_tile | input | TILE_W | Tile identifier to store |
| lkp_valid | input | 1 | Lookup request |
| lkp_addr | input | ADDR_W | Physical address to map |
| rsp_valid | output | 1 | Response is valid (one cycle after the request) |
| rsp_tile | output | TILE_W | Home tile identifier |

## Verification
The assertions assume that inputs change only away from the rising edge and that cfg_idx and lkp_addr are known whenever their enables are high. The bench drives every input on the falling edge and keeps the indexes and addresses at defined values at all times. The properties relating writes to later lookups assume that only one write lands per edge. The single configuration port guarantees this, and the bench issues at most one write per cycle, including in the cycle where a write and a lookup of the same entry collide.

// File: rtl/home_tile_pkg.sv
package home_tile_pkg;
  localparam int unsigned DEF_ADDR_W = 40;
  localparam int unsigned DEF_OFS_W  = 6;
  localparam int unsigned DEF_IDX_W  = 6;
  localparam int unsigned DEF_TILE_W = 6;
  localparam int unsigned DEF_LOCAL  = 13;

  // number of table entries for a given index width
  function automatic int unsigned entries_for(input int unsigned idx_w);
    return 32'd1 << idx_w;
  endfunction
endpackage

// File: rtl/home_idx_slice.sv
module home_idx_slice #(
  parameter int unsigned ADDR_W = 40,
  parameter int unsigned OFS_W  = 6,
  parameter int unsigned IDX_W  = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx
);
  localparam int unsigned TOP_W = ADDR_W - OFS_W - IDX_W;

  // block-number low bits just above the block offset
  function automatic logic [IDX_W-1:0] index_of(input logic [ADDR_W-1:0] a);
    return a[OFS_W +: IDX_W];
  endfunction

  assign idx = index_of(addr);

  logic unused_addr_bits;
  generate
    if (TOP_W > 0) begin : g_top
      assign unused_addr_bits = ^{addr[ADDR_W-1 -: TOP_W], addr[OFS_W-1:0]};
    end else begin : g_notop
      assign unused_addr_bits = ^addr[OFS_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/home_entry_bank.sv
module home_entry_bank #(
  parameter int unsigned IDX_W      = 6,
  parameter int unsigned TILE_W     = 6,
  parameter int unsigned LOCAL_TILE = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TILE_W-1:0] wr_tile,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [TILE_W-1:0] rd_tile
);
  localparam int unsigned DEPTH = home_tile_pkg::entries_for(IDX_W);
  localparam logic [TILE_W-1:0] RST_TILE = TILE_W'(LOCAL_TILE);

  logic [TILE_W-1:0] ent [DEPTH];
  logic [DEPTH-1:0]  hit;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      assign hit[i] = wr_en && (wr_idx == IDX_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ent[i] <= RST_TILE;
        else if (hit[i]) ent[i] <= wr_tile;
      end

      // R6: entries not addressed by a write stay as they were
      assert_untouched_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !hit[i] |=> $stable(ent[i]));
    end
  endgenerate

  assign rd_tile = ent[rd_idx];

  // R4: written value is present in the addressed entry after the edge
  assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ent[$past(wr_idx)] == $past(wr_tile));

  // at most one entry written per edge (atomic single-entry update)
  assert_single_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));
endmodule

// File: rtl/home_rsp_stage.sv
module home_rsp_stage #(
  parameter int unsigned TILE_W     = 6,
  parameter int unsigned LOCAL_TILE = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [TILE_W-1:0] tile_in,
  output logic              vld,
  output logic [TILE_W-1:0] tile_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld      <= 1'b0;
      tile_out <= TILE_W'(LOCAL_TILE);
    end else begin
      vld <= req;
      if (req) tile_out <= tile_in;
    end
  end

  assert_rsp_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> vld);
  assert_no_spurious_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !vld);
  assert_tile_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> $stable(tile_out));
endmodule

// File: rtl/home_tile_map.sv
module home_tile_map #(
  parameter int unsigned ADDR_W     = home_tile_pkg::DEF_ADDR_W,
  parameter int unsigned OFS_W      = home_tile_pkg::DEF_OFS_W,
  parameter int unsigned IDX_W      = home_tile_pkg::DEF_IDX_W,
  parameter int unsigned TILE_W     = home_tile_pkg::DEF_TILE_W,
  parameter int unsigned LOCAL_TILE = home_tile_pkg::DEF_LOCAL
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [TILE_W-1:0] cfg_tile,
  input  logic              lkp_valid,
  input  logic [ADDR_W-1:0] lkp_addr,
  output logic              rsp_valid,
  output logic [TILE_W-1:0] rsp_tile
);
  logic [IDX_W-1:0]  lkp_idx;
  logic [TILE_W-1:0] cur_tile;
  logic              collide;

  home_idx_slice #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .IDX_W(IDX_W)) u_slice (
    .addr(lkp_addr), .idx(lkp_idx));

  home_entry_bank #(.IDX_W(IDX_W), .TILE_W(TILE_W), .LOCAL_TILE(LOCAL_TILE)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we), .wr_idx(cfg_idx), .wr_tile(cfg_tile),
    .rd_idx(lkp_idx), .rd_tile(cur_tile));

  home_rsp_stage #(.TILE_W(TILE_W), .LOCAL_TILE(LOCAL_TILE)) u_rsp (
    .clk(clk), .rst_n(rst_n),
    .req(lkp_valid), .tile_in(cur_tile),
    .vld(rsp_valid), .tile_out(rsp_tile));

  // same-edge write and lookup of one entry
  assign collide = cfg_we && lkp_valid && (cfg_idx == lkp_idx);

  // R5: a colliding lookup reports the pre-write content
  assert_collide_old_R5: assert property (@(posedge clk) disable iff (!rst_n)
    collide |=> rsp_tile == $past(cur_tile));

  // R4: a lookup right after a write to the same entry sees the new value
  assert_next_sees_new_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (lkp_valid && lkp_idx == $past(cfg_idx)) |-> cur_tile == $past(cfg_tile));
endmodule

// File: tb/home_tile_map_test.sv
`timescale 1ns/1ps
module home_tile_map_test;
  localparam int AW = 40;
  localparam int LOC = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [5:0] cfg_idx = '0;
  logic [5:0] cfg_tile = '0;
  logic lkp_valid = 1'b0;
  logic [AW-1:0] lkp_addr = '0;
  logic rsp_valid;
  logic [5:0] rsp_tile;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  int model [64];
  int last_tile = LOC;

  always #2.5 clk = ~clk;

  home_tile_map uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_tile(cfg_tile),
    .lkp_valid(lkp_valid), .lkp_addr(lkp_addr), .rsp_valid(rsp_valid), .rsp_tile(rsp_tile));

  // entry number: divide away 64-byte blocks, keep 64 entries
  function automatic int entry_of(input logic [AW-1:0] a);
    return int'((a / 64) % 64);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one cycle: drive at falling edge, let a rising edge pass, sample at next falling edge
  task automatic cyc(input bit we, input int widx, input int wt, input bit lv,
                     input logic [AW-1:0] la, input string req);
    int exp_t;
    cfg_we = we; cfg_idx = 6'(widx); cfg_tile = 6'(wt);
    lkp_valid = lv; lkp_addr = la;
    exp_t = lv ? model[entry_of(la)] : last_tile;
    @(negedge clk);
    if (we) model[widx] = wt;
    last_tile = exp_t;
    check(req, int'(rsp_valid), int'(lv));
    check(req, int'(rsp_tile), exp_t);
    cfg_we = 1'b0; lkp_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cfg_we = 1'b0; lkp_valid = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 64; i++) model[i] = LOC;
    last_tile = LOC;
    check("R1 valid low in reset", int'(rsp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid low after reset", int'(rsp_valid), 0);
  endtask

  function automatic logic [AW-1:0] mk(input int hi, input int ent, input int ofs);
    return (AW'(hi) << 12) | (AW'(ent) << 6) | AW'(ofs);
  endfunction

  // table: {write index, write tile, lookup address hi, lookup entry, lookup offset}
  localparam int NV = 8;
  localparam int VEC [NV][5] = '{
    '{5,  12, 0,     5,  0},
    '{6,  12, 3,     6,  17},
    '{7,  14, 100,   5,  63},
    '{8,  14, 7,     7,  1},
    '{63, 2,  4095,  63, 32},
    '{0,  63, 1,     0,  0},
    '{9,  12, 55,    9,  8},
    '{1,  0,  2,     1,  40}
  };

  initial begin
    do_reset();
    // R1: several entries read back as the local tile after reset
    cyc(0, 0, 0, 1, mk(0, 0, 0),   "R1 entry 0");
    cyc(0, 0, 0, 1, mk(9, 33, 5),  "R1 entry 33");
    cyc(0, 0, 0, 1, mk(1, 63, 63), "R1 entry 63");

    // vector walk: write, then look up (R4, R7 shared tile ids)
    for (int v = 0; v < NV; v++) begin
      cyc(1, VEC[v][0], VEC[v][1], 0, '0, "R3 idle during write");
      cyc(0, 0, 0, 1, mk(VEC[v][2], VEC[v][3], VEC[v][4]), "R4 R7 lookup after write");
    end

    // R2: offset and upper bits ignored
    cyc(0, 0, 0, 1, mk(0,    5, 0),  "R2 base");
    cyc(0, 0, 0, 1, mk(999,  5, 63), "R2 high and offset bits");
    cyc(0, 0, 0, 1, mk(1234, 6, 31), "R2 different entry");

    // R5: same-edge write and lookup of entry 20 -> old, then new
    cyc(1, 20, 41, 1, mk(3, 20, 0), "R5 collide old value");
    check("R5 old value literal", int'(rsp_tile), LOC);
    cyc(0, 0, 0, 1, mk(8, 20, 9), "R5 new value next");
    check("R5 new value literal", int'(rsp_tile), 41);

    // R6: neighbours of entry 20 untouched
    cyc(0, 0, 0, 1, mk(0, 19, 0), "R6 entry 19");
    cyc(0, 0, 0, 1, mk(0, 21, 0), "R6 entry 21");

    // R8 / R3: idle cycles keep tile, valid drops
    cyc(1, 30, 7, 0, '0, "R8 hold during write");
    cyc(0, 0, 0, 0, '0, "R8 hold idle");
    cyc(0, 0, 0, 1, mk(0, 30, 0), "R4 entry 30");

    // R7: back-to-back lookups across many entries sharing ids
    for (int e = 40; e < 48; e++) cyc(1, e, (e % 2) ? 3 : 4, 0, '0, "R7 fill");
    for (int e = 40; e < 48; e++) cyc(0, 0, 0, 1, mk(e, e, e), "R7 shared ids");

    // R1: reset restores the local tile everywhere
    do_reset();
    cyc(0, 0, 0, 1, mk(0, 5, 0),  "R1 restored 5");
    cyc(0, 0, 0, 1, mk(0, 20, 0), "R1 restored 20");
    check("R1 literal", int'(rsp_tile), LOC);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule